// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block sits beside the address/data pads of a multiplexed 32-bit bus agent. It guards the parity line in two directions. On the receive side it watches the bus handshake strobes. It captures the address/data and command/byte-enable lines in each clock that carries a parity-protected value this agent should check. In the next clock it compares the incoming parity bit against the value it expected. A mismatch raises a one-cycle error pulse, kept apart for address phases and for data phases.

On the transmit side it takes the word the local agent is putting on the bus, either as data or as a parked idle value. It makes the parity bit for that word and presents it one clock later, together with an output enable for the parity pad. That enable trails the address/data enable by one clock, both when it turns on and when it turns off. The role inputs tell the block whether this agent started the transfer and whether the transfer is a read. From these it decides which data phases it receives and so must check.

Top module: `pci_parity_unit`

## Requirements
- R1: The expected parity bit is the XOR of the 32 address/data bits and the 4 command/byte-enable bits, so that those 36 bits together with a correct parity bit hold an even number of ones. A sampled parity bit that breaks this is an error.
- R2: When `frame_n` is low in a clock and was high in the clock before, and `role_init` is 0 (this agent is not the initiator), the bus word of that clock is an address. `bus_par` is compared at the next rising edge, and `addr_par_err` is 1 for exactly the one cycle after that edge if it mismatches. When `role_init` is 1, no address check is made.
- R3: A clock in which `frame_n` stays low from the previous clock starts no address check.
- R4: A data phase completes in a clock where `irdy_n` and `trdy_n` are both 0. For a write (`role_read`=0) received as target (`role_init`=0), `bus_par` is compared at the next edge and `data_par_err` pulses for one cycle on mismatch. Back-to-back phases are each checked.
- R5: For a read (`role_read`=1) received as initiator (`role_init`=1), completed data phases are checked in the same way as in R4.
- R6: A clock with only one of `irdy_n`, `trdy_n` low is a wait state and starts no data check.
- R7: A completed data phase for which this agent is the data source (`role_read` differs from `role_init`) starts no data check.
- R8: `ad_oe` is 1 whenever `drv_req` is 1. After each edge where `ad_oe` was 1, `par_oe` is 1 and `par_out` equals the XOR of `drv_ad` and `drv_cbe` from that edge.
- R9: After `ad_oe` falls, `par_oe` stays 1 for one more clock and then goes to 0.
- R10: Parking: with `gnt_n`=0 and both `frame_n` and `irdy_n` high, `ad_oe` is 1 even when `drv_req` is 0, and the parity of the parked word follows per R8. With `frame_n` or `irdy_n` low, parking does not enable `ad_oe`.
- R11: While `rst_n` is 0, `addr_par_err`, `data_par_err` and `par_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_ad | input | 32 | Address/data lines as seen on the bus |
| bus_cbe | input | 4 | Command/byte-enable lines as seen on the bus |
| bus_par | input | 1 | Parity line as seen on the bus |
| frame_n | input | 1 | Transfer framing strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| gnt_n | input | 1 | Bus grant to this agent, active low |
| role_init | input | 1 | 1 = this agent initiated the current transfer |
| role_read | input | 1 | 1 = current transfer is a read |
| drv_ad | input | 32 | Address/data value the local agent drives |
| drv_cbe | input | 4 | Command/byte-enable value the local agent drives |
| drv_req | input | 1 | Local agent drives address/data this clock |
| ad_oe | output | 1 | Address/data/command pad enable (drive or park) |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Parity pad enable, one clock behind `ad_oe` |
| addr_par_err | output | 1 | One-cycle pulse on address parity mismatch |
| data_par_err | output | 1 | One-cycle pulse on data parity mismatch |

## Verification
The bench walks a single one across all 36 covered bits, with correct and flipped parity, through address phases and through every role combination of data phases. A design that checked the wrong clock, dropped a bit from the XOR or checked the agent's own driven data would flag or miss errors there. Wait states, continued framing and back-to-back completed phases are driven on purpose. A checker that keyed on one strobe alone or lost its pipeline stage would pulse at the wrong time or merge two phases. On the drive side, the bench watches the one-clock gap where the parity enable must still be on after the address/data enable drops. It also checks parking under idle and busy bus states, where an early-dropping or never-parking enable shows up.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  typedef enum logic [0:0] {
    CH_ADDR = 1'b0,
    CH_DATA = 1'b1
  } par_ch_e;

  localparam int unsigned NUM_CH = 2;

  typedef struct packed {
    logic valid;
    logic expect_par;
  } par_stage_t;

endpackage

// File: rtl/pci_par_phase_qual.sv
module pci_par_phase_qual
  import pci_par_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic              role_init,
  input  logic              role_read,
  output logic [NUM_CH-1:0] qual
);

  logic frame_seen_q;
  logic frame_seen_d;

  always_comb begin
    frame_seen_d = !frame_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_seen_q <= 1'b0;
    else        frame_seen_q <= frame_seen_d;
  end

  always_comb begin
    qual = '0;
    // address: first clock of framing, only when another agent drives it
    qual[int'(CH_ADDR)] = !frame_n && !frame_seen_q && !role_init;
    // data: completed phase that this agent receives
    qual[int'(CH_DATA)] = !irdy_n && !trdy_n && (role_read == role_init);
  end

  // R3
  addr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qual[int'(CH_ADDR)] |=> !qual[int'(CH_ADDR)])
    else $error("address qualifier held for two clocks");

endmodule

// File: rtl/pci_par_lane.sv
module pci_par_lane
  import pci_par_pkg::*;
#(
  parameter int unsigned WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qual,
  input  logic [WORD_W-1:0] word,
  input  logic              par_in,
  output logic              err
);

  par_stage_t stage_q;
  par_stage_t stage_d;
  logic       err_q;
  logic       err_d;
  logic       stage_valid;
  logic       stage_expect;

  always_comb begin
    stage_d.valid      = qual;
    stage_d.expect_par = qual ? ^word : stage_q.expect_par;
    err_d              = stage_q.valid && (par_in != stage_q.expect_par);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      err_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      err_q   <= err_d;
    end
  end

  assign err          = err_q;
  assign stage_valid  = stage_q.valid;
  assign stage_expect = stage_q.expect_par;

  // R1
  err_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_valid |=> (err_q == ($past(par_in) ^ $past(stage_expect))))
    else $error("parity compare result wrong");

  // R2
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(stage_valid))
    else $error("error without a captured phase");

endmodule

// File: rtl/pci_par_drive.sv
module pci_par_drive #(
  parameter int unsigned WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gnt_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              drv_req,
  input  logic [WORD_W-1:0] drv_word,
  output logic              ad_oe,
  output logic              par_out,
  output logic              par_oe
);

  logic park;
  logic par_q, par_d;
  logic oe_q, oe_d;
  logic armed_q, armed_d;

  always_comb begin
    park    = !gnt_n && frame_n && irdy_n;
    ad_oe   = drv_req || park;
    par_d   = ad_oe ? ^drv_word : par_q;
    oe_d    = ad_oe;
    armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q   <= 1'b0;
      oe_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      par_q   <= par_d;
      oe_q    <= oe_d;
      armed_q <= armed_d;
    end
  end

  assign par_out = par_q;
  assign par_oe  = oe_q;

  // R8
  par_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && !par_oe) |=> par_oe)
    else $error("parity enable did not follow");

  // R9
  par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    $fell(ad_oe) |-> par_oe)
    else $error("parity enable dropped with pad enable");

  // R9
  par_off_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    $fell(ad_oe) |=> !par_oe)
    else $error("parity enable stayed on too long");

  // R8
  parity_even_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    par_oe |-> ((^{$past(drv_word), par_out}) == 1'b0))
    else $error("driven parity not even");

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pci_par_pkg::*;
#(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  bus_ad,
  input  logic [CBE_W-1:0] bus_cbe,
  input  logic             bus_par,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             trdy_n,
  input  logic             gnt_n,
  input  logic             role_init,
  input  logic             role_read,
  input  logic [AD_W-1:0]  drv_ad,
  input  logic [CBE_W-1:0] drv_cbe,
  input  logic             drv_req,
  output logic             ad_oe,
  output logic             par_out,
  output logic             par_oe,
  output logic             addr_par_err,
  output logic             data_par_err
);

  localparam int unsigned WORD_W = AD_W + CBE_W;

  logic [WORD_W-1:0] bus_word;
  logic [WORD_W-1:0] drv_word;
  logic [NUM_CH-1:0] qual;
  logic [NUM_CH-1:0] err_vec;

  assign bus_word = {bus_ad, bus_cbe};
  assign drv_word = {drv_ad, drv_cbe};

  pci_par_phase_qual u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .trdy_n    (trdy_n),
    .role_init (role_init),
    .role_read (role_read),
    .qual      (qual)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    pci_par_lane #(.WORD_W(WORD_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .qual   (qual[ch]),
      .word   (bus_word),
      .par_in (bus_par),
      .err    (err_vec[ch])
    );
  end

  assign addr_par_err = err_vec[int'(CH_ADDR)];
  assign data_par_err = err_vec[int'(CH_DATA)];

  pci_par_drive #(.WORD_W(WORD_W)) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .gnt_n    (gnt_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .drv_req  (drv_req),
    .drv_word (drv_word),
    .ad_oe    (ad_oe),
    .par_out  (par_out),
    .par_oe   (par_oe)
  );

  // R2
  addr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_par_err |=> !addr_par_err)
    else $error("address error longer than one cycle");

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!addr_par_err && !data_par_err && !par_oe))
    else $error("outputs active in reset");

endmodule

// File: tb/pci_parity_unit_bench.sv
module pci_parity_unit_bench;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] bus_ad;
  logic [3:0]  bus_cbe;
  logic        bus_par;
  logic        frame_n, irdy_n, trdy_n, gnt_n;
  logic        role_init, role_read;
  logic [31:0] drv_ad;
  logic [3:0]  drv_cbe;
  logic        drv_req;
  logic        ad_oe, par_out, par_oe, addr_par_err, data_par_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_parity_unit u_pci_parity_unit (
    .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .bus_cbe(bus_cbe), .bus_par(bus_par),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .gnt_n(gnt_n),
    .role_init(role_init), .role_read(role_read), .drv_ad(drv_ad), .drv_cbe(drv_cbe),
    .drv_req(drv_req), .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe),
    .addr_par_err(addr_par_err), .data_par_err(data_par_err)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_bus(input logic [35:0] w);
    {bus_ad, bus_cbe} = w;
  endtask

  // one receive data phase followed by its parity clock
  task automatic data_phase(input logic init, input logic rd, input logic irdy_v,
                            input logic trdy_v, input logic [35:0] w, input bit bad,
                            input logic exp_err, input string req);
    role_init = init; role_read = rd;
    irdy_n = irdy_v; trdy_n = trdy_v;
    set_bus(w);
    step();
    irdy_n = 1'b1; trdy_n = 1'b1;
    bus_par = (^w) ^ bad;
    set_bus(~w);
    step();
    check(req, data_par_err, exp_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_ad = '0; bus_cbe = '0; bus_par = 1'b0;
    frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; gnt_n = 1'b1;
    role_init = 1'b0; role_read = 1'b0;
    drv_ad = '0; drv_cbe = '0; drv_req = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11 addr err", addr_par_err, 1'b0);
    check("R11 data err", data_par_err, 1'b0);
    check("R11 par_oe", par_oe, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step();

    // R2 R3 R1: address phases, walking one, good and bad parity
    for (int i = 0; i < 36; i++) begin
      for (int b = 0; b < 2; b++) begin
        logic [35:0] w;
        w = 36'd1 << i;
        frame_n = 1'b1; role_init = 1'b0;
        step();
        frame_n = 1'b0; set_bus(w); bus_par = 1'b0;
        step();
        bus_par = (^w) ^ b[0]; set_bus(~w);
        step();
        check("R2 address check", addr_par_err, b[0]);
        check("R1 no data err on address", data_par_err, 1'b0);
        bus_par = ~bus_par;
        step();
        check("R3 continued frame", addr_par_err, 1'b0);
      end
    end

    // R2 initiator does not check address
    frame_n = 1'b1; role_init = 1'b1; step();
    frame_n = 1'b0; set_bus(36'h5_A5A5_A5A5); step();
    bus_par = ~(^36'h5_A5A5_A5A5); step();
    check("R2 initiator skip", addr_par_err, 1'b0);

    // data phases: frame stays low from here
    step();
    for (int i = 0; i < 36; i++) begin
      for (int b = 0; b < 2; b++) begin
        for (int m = 0; m < 4; m++) begin
          logic init, rd;
          logic [35:0] w;
          w = 36'd1 << i;
          init = m[1]; rd = m[0];
          if (!init && !rd)
            data_phase(init, rd, 1'b0, 1'b0, w, b[0], b[0], "R4 write target");
          else if (init && rd)
            data_phase(init, rd, 1'b0, 1'b0, w, b[0], b[0], "R5 read initiator");
          else
            data_phase(init, rd, 1'b0, 1'b0, w, b[0], 1'b0, "R7 own data");
        end
      end
    end

    // R6 wait states
    data_phase(1'b0, 1'b0, 1'b0, 1'b1, 36'h1_2345_6789, 1'b1, 1'b0, "R6 irdy only");
    data_phase(1'b0, 1'b0, 1'b1, 1'b0, 36'h1_2345_6789, 1'b1, 1'b0, "R6 trdy only");
    data_phase(1'b1, 1'b1, 1'b0, 1'b1, 36'hF_0F0F_0F0F, 1'b1, 1'b0, "R6 read wait");

    // R4 back-to-back: first bad, second good
    role_init = 1'b0; role_read = 1'b0;
    irdy_n = 1'b0; trdy_n = 1'b0; set_bus(36'h3); step();
    bus_par = ~(^36'h3); set_bus(36'h7); step();
    check("R4 back-to-back first", data_par_err, 1'b1);
    irdy_n = 1'b1; trdy_n = 1'b1; bus_par = ^36'h7; step();
    check("R4 back-to-back second", data_par_err, 1'b0);

    // drive side, bus busy, no grant
    frame_n = 1'b1; irdy_n = 1'b1; gnt_n = 1'b1; step();
    for (int i = 0; i < 36; i++) begin
      logic [35:0] w;
      w = (36'd1 << i) | 36'h8_0000_0001;
      drv_req = 1'b1; {drv_ad, drv_cbe} = w;
      #1;
      check("R8 ad_oe on request", ad_oe, 1'b1);
      step();
      check("R8 par_oe", par_oe, 1'b1);
      check("R8 par_out", par_out, ^w);
    end
    drv_req = 1'b0; {drv_ad, drv_cbe} = 36'hA_AAAA_AAAB;
    #1;
    check("R9 ad_oe off", ad_oe, 1'b0);
    check("R9 par_oe still on", par_oe, 1'b1);
    step();
    check("R9 par_oe off", par_oe, 1'b0);

    // R10 parking
    gnt_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; {drv_ad, drv_cbe} = 36'h0_0000_0007;
    #1;
    check("R10 park ad_oe", ad_oe, 1'b1);
    step();
    check("R10 park par_oe", par_oe, 1'b1);
    check("R10 park par_out", par_out, 1'b1);
    frame_n = 1'b0;
    #1;
    check("R10 busy frame no park", ad_oe, 1'b0);
    frame_n = 1'b1; irdy_n = 1'b0;
    #1;
    check("R10 busy irdy no park", ad_oe, 1'b0);
    step();
    check("R10 par_oe trails park", par_oe, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule